// File: doc/BRIEF.md
# Byte Shuffle and Shift Unit

This block is the byte-manipulation and shift slice of a 64-bit integer execution pipe. It takes a data operand A, a second operand B and a 7-bit function code, and produces a 64-bit result in the same cycle. It performs three kinds of work. The first is logical and arithmetic shifts. The second is paired low/high mask, extract and insert operations, which let software assemble and disassemble unaligned 1, 2, 4 or 8 byte fields from two aligned quadwords. The third is byte-granular zeroing driven by an 8-bit select mask.

For shifts, the count is B[5:0]. For mask, extract and insert, the byte offset is B[2:0]. For zeroing, the byte-select mask is B[7:0]. No other bit of B has any effect. A code the unit does not implement raises an illegal-operation flag and forces the result to zero.

Top module: `byte_shuffle_unit`

## Requirements
- R1: Codes 0x39, 0x34 and 0x3c shift A by B[5:0]: left logical, right logical, and right arithmetic (sign fill) respectively.
- R2: Mask-low codes 0x02, 0x12, 0x22, 0x32 (field 1, 2, 4, 8 bytes) clear in A the bytes k with offset <= k < offset+width. Bytes that would lie past byte 7 are dropped.
- R3: Mask-high codes 0x52, 0x62, 0x72 (2, 4, 8 bytes) return A unchanged when the offset is 0. Otherwise they clear bytes k < offset+width-8.
- R4: Extract-low codes 0x06, 0x16, 0x26, 0x36 (1, 2, 4, 8 bytes) return A shifted right by 8*offset bits, keeping only the low width bytes.
- R5: Extract-high codes 0x5a, 0x6a, 0x7a (2, 4, 8 bytes) return A shifted left by (64-8*offset) mod 64 bits, keeping only the low width bytes.
- R6: Insert-low codes 0x0b, 0x1b, 0x2b, 0x3b (1, 2, 4, 8 bytes) return the low width bytes of A shifted left by 8*offset bits.
- R7: Insert-high codes 0x57, 0x67, 0x77 (2, 4, 8 bytes) return 0 when the offset is 0. Otherwise they return the low width bytes of A shifted right by 64-8*offset bits.
- R8: Code 0x30 zeroes byte i of A for each set bit i of B[7:0]. Code 0x31 zeroes byte i for each clear bit i.
- R9: Any other code sets illegal_op to 1 and drives the result to 0. Every listed code drives illegal_op to 0.
- R10: The result depends only on the current inputs, in the same cycle. Bits of B above the field each operation uses (B[63:6] for shifts, B[63:3] for offset operations, B[63:8] for zeroing) have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | Data operand |
| op_b | input | 64 | Shift count, byte offset or byte-select mask |
| func_code | input | 7 | Operation select |
| result | output | 64 | Combinational result |
| illegal_op | output | 1 | High for an unimplemented function code |

## Verification
Every result and the illegal flag are combinational, so each is due in the same cycle its inputs are applied. The bench drives inputs just after a falling edge and samples 1 ns after the following rising edge. By that point the data path has had more than half a period to settle, and the next stimulus has not yet arrived. The sweep covers all 128 function codes, 256 values of the low byte of B and three A patterns. The upper bits of B carry a changing filler value, so any dependence on them shows up as a mismatch.

// File: rtl/byte_shuffle_pkg.sv
package byte_shuffle_pkg;

  localparam int WSEL_W = 2;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_SLL,
    OP_SRL,
    OP_SRA,
    OP_MSKL,
    OP_MSKH,
    OP_EXTL,
    OP_EXTH,
    OP_INSL,
    OP_INSH,
    OP_ZAP,
    OP_ZAPNOT
  } opKind_e;

  typedef struct packed {
    opKind_e           kind;
    logic [WSEL_W-1:0] widthSel;  // field is 2**widthSel bytes
    logic              illegal;
  } byteCtl_t;

endpackage

// File: rtl/byte_shuffle_ctrl.sv
module byte_shuffle_ctrl
  import byte_shuffle_pkg::*;
#(
  parameter int FUNC_W = 7
) (
  input  logic [FUNC_W-1:0] funcCode,
  output byteCtl_t          ctl
);

  always_comb begin
    ctl.kind     = OP_NONE;
    ctl.widthSel = funcCode[5:4];
    ctl.illegal  = 1'b0;
    case (funcCode)
      7'h39: ctl.kind = OP_SLL;
      7'h34: ctl.kind = OP_SRL;
      7'h3c: ctl.kind = OP_SRA;
      7'h02, 7'h12, 7'h22, 7'h32: ctl.kind = OP_MSKL;
      7'h52, 7'h62, 7'h72:        ctl.kind = OP_MSKH;
      7'h06, 7'h16, 7'h26, 7'h36: ctl.kind = OP_EXTL;
      7'h5a, 7'h6a, 7'h7a:        ctl.kind = OP_EXTH;
      7'h0b, 7'h1b, 7'h2b, 7'h3b: ctl.kind = OP_INSL;
      7'h57, 7'h67, 7'h77:        ctl.kind = OP_INSH;
      7'h30: ctl.kind = OP_ZAP;
      7'h31: ctl.kind = OP_ZAPNOT;
      default: ctl.illegal = 1'b1;
    endcase
  end

  // R1
  always_comb begin
    if (!$isunknown(funcCode) && (funcCode == 7'h39 || funcCode == 7'h34 || funcCode == 7'h3c))
      shift_legal_chk: assert (!ctl.illegal);
  end

endmodule

// File: rtl/byte_shuffle_dp.sv
module byte_shuffle_dp
  import byte_shuffle_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  byteCtl_t          ctl,
  output logic [DATA_W-1:0] dpResult
);

  localparam int BYTES   = DATA_W / 8;
  localparam int OFS_W   = $clog2(BYTES);
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int CMP_W   = SHAMT_W + 1;

  logic [OFS_W-1:0]   byteOfs;
  logic [SHAMT_W-1:0] shiftAmt;
  logic [SHAMT_W-1:0] byteShift;
  logic [CMP_W-1:0]   compShift;
  logic [DATA_W-1:0]  fieldMask;
  logic [DATA_W-1:0]  selMask;
  logic [DATA_W-1:0]  fieldA;
  logic               unusedHighB;

  assign byteOfs     = opB[OFS_W-1:0];
  assign shiftAmt    = opB[SHAMT_W-1:0];
  assign byteShift   = {byteOfs, 3'b000};
  assign compShift   = CMP_W'(DATA_W) - CMP_W'(byteShift);
  assign unusedHighB = |opB[DATA_W-1:BYTES];

  // byte-wide expansion of the select mask and the field-width mask
  for (genvar k = 0; k < BYTES; k++) begin : g_bytes
    assign selMask[k*8 +: 8]   = {8{opB[k]}};
    assign fieldMask[k*8 +: 8] = (k < (1 << ctl.widthSel)) ? 8'hFF : 8'h00;
  end

  assign fieldA = opA & fieldMask;

  always_comb begin
    dpResult = '0;
    case (ctl.kind)
      OP_SLL:    dpResult = opA << shiftAmt;
      OP_SRL:    dpResult = opA >> shiftAmt;
      OP_SRA:    dpResult = $signed(opA) >>> shiftAmt;
      OP_MSKL:   dpResult = opA & ~(fieldMask << byteShift);
      OP_MSKH:   dpResult = (byteOfs == '0) ? opA : (opA & ~(fieldMask >> compShift));
      OP_EXTL:   dpResult = (opA >> byteShift) & fieldMask;
      OP_EXTH:   dpResult = (opA << compShift[SHAMT_W-1:0]) & fieldMask;
      OP_INSL:   dpResult = fieldA << byteShift;
      OP_INSH:   dpResult = (byteOfs == '0) ? '0 : (fieldA >> compShift);
      OP_ZAP:    dpResult = opA & ~selMask;
      OP_ZAPNOT: dpResult = opA & selMask;
      default:   dpResult = '0;
    endcase
  end

  // R3
  always_comb begin
    if (!$isunknown({opA, opB, ctl}) && ctl.kind == OP_MSKH && byteOfs == '0)
      mskh_pass_chk: assert (dpResult == opA);
  end

  // R7
  always_comb begin
    if (!$isunknown({opA, opB, ctl}) && ctl.kind == OP_INSH && byteOfs == '0)
      insh_zero_chk: assert (dpResult == '0);
  end

  // R4
  always_comb begin
    if (!$isunknown({opA, opB, ctl}) && ctl.kind == OP_EXTL && ctl.widthSel == '0)
      extl_width_chk: assert (dpResult[DATA_W-1:8] == '0);
  end

  // R1
  always_comb begin
    if (!$isunknown({opA, opB, ctl}) && ctl.kind == OP_SLL && shiftAmt == '0)
      sll_zero_chk: assert (dpResult == opA);
  end

endmodule

// File: rtl/byte_shuffle_unit.sv
module byte_shuffle_unit
  import byte_shuffle_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int FUNC_W = 7
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [FUNC_W-1:0] func_code,
  output logic [DATA_W-1:0] result,
  output logic              illegal_op
);

  byteCtl_t          ctl;
  logic [DATA_W-1:0] dpResult;

  byte_shuffle_ctrl #(.FUNC_W(FUNC_W)) i_ctrl (
    .funcCode (func_code),
    .ctl      (ctl)
  );

  byte_shuffle_dp #(.DATA_W(DATA_W)) i_dp (
    .opA      (op_a),
    .opB      (op_b),
    .ctl      (ctl),
    .dpResult (dpResult)
  );

  assign illegal_op = ctl.illegal;
  assign result     = ctl.illegal ? '0 : dpResult;

  // R9
  always_comb begin
    if (!$isunknown({op_a, op_b, func_code}) && illegal_op)
      illegal_zero_chk: assert (result == '0);
  end

endmodule

// File: tb/test_byte_shuffle_unit.sv
module test_byte_shuffle_unit;

  logic        clk = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [6:0]  func_code = '0;
  logic [63:0] result;
  logic        illegal_op;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  byte_shuffle_unit i_byte_shuffle_unit (
    .op_a       (op_a),
    .op_b       (op_b),
    .func_code  (func_code),
    .result     (result),
    .illegal_op (illegal_op)
  );

  function automatic logic [7:0] byt(input logic [63:0] v, input int k);
    return (k >= 0 && k < 8) ? v[k*8 +: 8] : 8'h00;
  endfunction

  // Reference model built per byte / per bit from the requirements.
  function automatic logic [63:0] model(input logic [6:0] c, input logic [63:0] a,
                                        input logic [63:0] b, output bit legal,
                                        output string tag);
    logic [63:0] r = '0;
    int ofs = int'(b[2:0]);
    int cnt = int'(b[5:0]);
    int w   = 1 << c[5:4];
    legal = 1;
    case (c)
      7'h39: begin tag = "R1"; for (int i = 0; i < 64; i++) r[i] = (i >= cnt) ? a[i-cnt] : 1'b0; end
      7'h34: begin tag = "R1"; for (int i = 0; i < 64; i++) r[i] = (i + cnt < 64) ? a[i+cnt] : 1'b0; end
      7'h3c: begin tag = "R1"; for (int i = 0; i < 64; i++) r[i] = (i + cnt < 64) ? a[i+cnt] : a[63]; end
      7'h02, 7'h12, 7'h22, 7'h32: begin
        tag = "R2";
        for (int k = 0; k < 8; k++) r[k*8 +: 8] = (k >= ofs && k < ofs + w) ? 8'h00 : byt(a, k);
      end
      7'h52, 7'h62, 7'h72: begin
        tag = "R3";
        for (int k = 0; k < 8; k++) r[k*8 +: 8] = (ofs != 0 && k < ofs + w - 8) ? 8'h00 : byt(a, k);
      end
      7'h06, 7'h16, 7'h26, 7'h36: begin
        tag = "R4";
        for (int k = 0; k < 8; k++) r[k*8 +: 8] = (k < w) ? byt(a, k + ofs) : 8'h00;
      end
      7'h5a, 7'h6a, 7'h7a: begin
        int s = (8 - ofs) % 8;
        tag = "R5";
        for (int k = 0; k < 8; k++) r[k*8 +: 8] = (k < w) ? byt(a, k - s) : 8'h00;
      end
      7'h0b, 7'h1b, 7'h2b, 7'h3b: begin
        tag = "R6";
        for (int k = 0; k < 8; k++) r[k*8 +: 8] = (k - ofs >= 0 && k - ofs < w) ? byt(a, k - ofs) : 8'h00;
      end
      7'h57, 7'h67, 7'h77: begin
        tag = "R7";
        for (int k = 0; k < 8; k++)
          r[k*8 +: 8] = (ofs != 0 && k + 8 - ofs < w) ? byt(a, k + 8 - ofs) : 8'h00;
      end
      7'h30: begin tag = "R8"; for (int k = 0; k < 8; k++) r[k*8 +: 8] = b[k] ? 8'h00 : byt(a, k); end
      7'h31: begin tag = "R8"; for (int k = 0; k < 8; k++) r[k*8 +: 8] = b[k] ? byt(a, k) : 8'h00; end
      default: begin tag = "R9"; legal = 0; r = '0; end
    endcase
    return r;
  endfunction

  task automatic check_now(input string tag, input logic [63:0] expR, input bit expIll);
    checks++;
    if (result !== expR || illegal_op !== expIll) begin
      errors++;
      $display("FAIL %s code=%02h a=%016h b=%016h result=%016h/ill=%0b expected %016h/ill=%0b",
               tag, func_code, op_a, op_b, result, illegal_op, expR, expIll);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual cycles %0d expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] aSet [3];
    logic [63:0] filler;
    logic [63:0] expR;
    bit          legal;
    string       tag;
    aSet[0] = 64'h8877_6655_4433_2211;
    aSet[1] = 64'hF0E1_D2C3_B4A5_9687;
    aSet[2] = 64'h0123_4567_89AB_CDEF;
    filler  = 64'h9E37_79B9_7F4A_7C15;

    // R9: idle inputs (code 0x00 is unlisted) give zero and the flag
    @(negedge clk);
    @(posedge clk); #1;
    check_now("R9", 64'h0, 1'b1);

    for (int ai = 0; ai < 3; ai++) begin
      for (int c = 0; c < 128; c++) begin
        for (int bl = 0; bl < 256; bl++) begin
          @(negedge clk);
          filler    = {filler[62:0], filler[63] ^ filler[61] ^ filler[60] ^ filler[58]};
          op_a      = aSet[ai];
          op_b      = {filler[63:8], 8'(bl)};  // R10: upper bits of B vary freely
          func_code = 7'(c);
          expR      = model(7'(c), op_a, op_b, legal, tag);
          @(posedge clk); #1;
          check_now(tag, expR, !legal);
        end
      end
    end

    // R10: same low byte, different upper B bits, identical result
    for (int c = 0; c < 128; c++) begin
      logic [63:0] first;
      @(negedge clk);
      op_a = aSet[1]; op_b = 64'h0000_0000_0000_00A5; func_code = 7'(c);
      @(posedge clk); #1;
      first = result;
      @(negedge clk);
      op_b = 64'hFFFF_FFFF_FFFF_FFA5;
      @(posedge clk); #1;
      checks++;
      if (result !== first) begin
        errors++;
        $display("FAIL R10 code=%02h result=%016h expected %016h", c, result, first);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule